// File: doc/BRIEF.md
# Cascadable Up/Down Binary Counter

This block is a synchronous binary counter of parameterised width (4 bits by default). While its step enable is high, it moves by one on each rising clock edge. The direction input picks whether it counts up or down. Every bit of the count updates on the same edge. A synchronous reset clears the count to zero.

Three wrap outputs are driven purely by combinational logic:
- The carry output goes high when an upward step will take the count from all ones to zero.
- The borrow output goes high when a downward step will take the count from zero to all ones.
- The wrap output is the OR of carry and borrow.

All three outputs are gated by the step enable. Wider counters are built by chaining identical stages on one shared clock. The wrap output of one stage drives the step enable of the next. In this way the whole chain advances in lockstep, in either direction.

Top module: `updown_stage`

## Requirements
- R1: While `step_en` is low, `count` holds its value across the clock edge.
- R2: With `step_en` high and `dir_up` = 1, `count` increases by one at the edge, modulo 2^WIDTH. All ones becomes zero.
- R3: With `step_en` high and `dir_up` = 0, `count` decreases by one at the edge, modulo 2^WIDTH. Zero becomes all ones.
- R4: `carry_o` is 1 exactly when `count` is all ones, `dir_up` = 1 and `step_en` = 1. It follows these inputs within the same cycle.
- R5: `borrow_o` is 1 exactly when `count` is zero, `dir_up` = 0 and `step_en` = 1. It follows these inputs within the same cycle.
- R6: `wrap_o` equals `carry_o` OR `borrow_o`. At most one of `carry_o` and `borrow_o` is high at any time.
- R7: With `rst` high at a clock edge, `count` becomes zero on that edge, whatever the other inputs are.
- R8: When two stages are chained, with the wrap output of the low stage driving the step enable of the high stage, the pair counts as one 2*WIDTH-bit counter in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every bit updates on its rising edge |
| rst | input | 1 | Synchronous reset, active high, clears the count |
| step_en | input | 1 | Step enable; the count moves only while it is high |
| dir_up | input | 1 | Direction: 1 counts up, 0 counts down |
| count | output | WIDTH | Current count value |
| carry_o | output | 1 | Upward wrap pending (all ones, up, enabled) |
| borrow_o | output | 1 | Downward wrap pending (zero, down, enabled) |
| wrap_o | output | 1 | OR of carry and borrow, used to enable the next stage |

## Verification
The checker assumes that `step_en` and `dir_up` are settled before each rising edge and carry no unknown values after reset. It also assumes reset is asserted at least once before any check applies. The stimulus changes inputs only on falling edges and holds reset for several cycles at the start. Its patterns are long runs in one direction, runs that cross both wrap points, and direction flips right at all ones and at zero. The bench also chains two stages to test lockstep behaviour across the 8-bit boundary.

// File: rtl/updown_stage.sv
module updown_stage #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_en,
  input  logic             dir_up,
  output logic [WIDTH-1:0] count,
  output logic             carry_o,
  output logic             borrow_o,
  output logic             wrap_o
);

  logic [WIDTH-1:0] toggle;

  // Bit i flips when every lower bit is 1 (up) or every lower bit is 0 (down).
  // Bit 0 always flips on a step.
  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_tog
      if (i == 0) begin : g_lsb
        assign toggle[i] = step_en;
      end else begin : g_hi
        assign toggle[i] = step_en &
                           (dir_up ? (&count[i-1:0]) : ~(|count[i-1:0]));
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else     count <= count ^ toggle;
  end

  assign carry_o  = step_en &  dir_up & (&count);
  assign borrow_o = step_en & ~dir_up & ~(|count);
  assign wrap_o   = carry_o | borrow_o;

endmodule

// File: rtl/updown_stage_chk.sv
module updown_stage_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             step_en,
  input logic             dir_up,
  input logic [WIDTH-1:0] count,
  input logic             carry_o,
  input logic             borrow_o,
  input logic             wrap_o
);

  logic seen_rst = 1'b0;
  always_ff @(posedge clk) if (rst) seen_rst <= 1'b1;

  assert_hold_R1: assert property (@(posedge clk) disable iff (rst || !seen_rst)
    !step_en |=> $stable(count));

  assert_up_R2: assert property (@(posedge clk) disable iff (rst || !seen_rst)
    (step_en && dir_up) |=> count == WIDTH'($past(count) + 1'b1));

  assert_down_R3: assert property (@(posedge clk) disable iff (rst || !seen_rst)
    (step_en && !dir_up) |=> count == WIDTH'($past(count) - 1'b1));

  assert_carry_next_R4: assert property (@(posedge clk) disable iff (rst || !seen_rst)
    carry_o |=> count == '0);

  assert_borrow_next_R5: assert property (@(posedge clk) disable iff (rst || !seen_rst)
    borrow_o |=> count == '1);

  assert_excl_R6: assert property (@(posedge clk) disable iff (rst || !seen_rst)
    $onehot0({carry_o, borrow_o}) && (wrap_o == (carry_o || borrow_o)));

  assert_reset_R7: assert property (@(posedge clk) disable iff (!seen_rst)
    rst |=> count == '0);

endmodule

bind updown_stage updown_stage_chk #(.WIDTH(WIDTH)) chk_i (.*);

// File: tb/updown_stage_tb_top.sv
module updown_stage_tb_top;
  localparam int W = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, en, up;
  logic [W-1:0] cnt, cnt_hi;
  logic cy, bw, wr, cy_hi, bw_hi, wr_hi;

  updown_stage #(.WIDTH(W)) dut_i (
    .clk(clk), .rst(rst), .step_en(en), .dir_up(up),
    .count(cnt), .carry_o(cy), .borrow_o(bw), .wrap_o(wr));

  updown_stage #(.WIDTH(W)) hi_i (
    .clk(clk), .rst(rst), .step_en(wr), .dir_up(up),
    .count(cnt_hi), .carry_o(cy_hi), .borrow_o(bw_hi), .wrap_o(wr_hi));

  int tests = 0, fails = 0;
  int model = 0;
  int model_wide = 0;

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Compare combinational outputs before the edge, then apply the model step.
  task automatic step(input logic e, input logic u, input logic r);
    en = e; up = u; rst = r;
    #1;
    if (!r) begin
      chk("R4", cy, (e && u && model == 15) ? 1 : 0);
      chk("R5", bw, (e && !u && model == 0) ? 1 : 0);
      chk("R6", wr, (cy | bw));
    end
    @(posedge clk);
    if (r) begin
      model = 0; model_wide = 0;
    end else if (e) begin
      model = u ? (model + 1) % 16 : (model + 15) % 16;
      model_wide = u ? (model_wide + 1) % 256 : (model_wide + 255) % 256;
    end
    @(negedge clk);
    if (r) chk("R7", cnt, 0);
    else if (!e) chk("R1", cnt, model);
    else if (u) chk("R2", cnt, model);
    else chk("R3", cnt, model);
    chk("R8", {cnt_hi, cnt}, model_wide);
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog R1 actual=hang expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    en = 0; up = 1; rst = 1;
    @(negedge clk);
    repeat (3) step(1, 1, 1);
    for (int k = 0; k < 20; k++) step(1, 1, 0);
    for (int k = 0; k < 5; k++) step(0, k[0], 0);
    for (int k = 0; k < 40; k++) step(1, 0, 0);
    while (model != 15) step(1, 1, 0);
    step(1, 0, 0);
    step(1, 1, 0);
    step(1, 1, 0);
    step(1, 0, 0);
    step(0, 0, 0);
    for (int k = 0; k < 300; k++) step(1, 1, 0);
    for (int k = 0; k < 300; k++) step(1, 0, 0);
    for (int k = 0; k < 60; k++) step(k % 3 != 0, k[2], 0);
    step(1, 1, 1);
    step(0, 0, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule